// File: doc/BRIEF.md
# Jitter-Tolerant Test Flit Buffer

This block sits between an on-chip tester port and a delivery fabric. The tester sends 32-bit flits at a fixed average rate of about one flit every four cycles. The fabric normally takes flits at that same rate. When the fabric has to retransmit, it stops taking flits for a while, which delays delivery. The block is a first-in first-out store whose depth covers the delay of one retransmission: 40 stalled cycles at one flit per four cycles is ten flits. The default depth of sixteen adds a margin above that.

The tester cuts its stream into segments and puts a short run of filler flits between them. Each written flit carries a marker bit that tells the buffer whether it is test data or filler. Filler has no effect on the test. When the buffer already holds a backlog, it discards incoming filler and so drains back toward its normal low occupancy. When the buffer is nearly empty, it stores the filler and passes it on, which keeps the downstream cadence steady.

The buffer raises an error flag if a flit is lost because the store is full. It also raises the flag if the fabric asks for a flit that the stream owes and the store is empty. The flag stays set until reset.

Top module: `jitter_buf`

## Requirements
- R1: While reset is asserted and after it is released, `rd_valid_o` and `err_o` are low until a flit has been written.
- R2: Data flits (`wr_fill_i`=0) leave on `rd_data_o` in the order they were written, with their payload unchanged. A presented head flit stays stable until it is taken.
- R3: A data write that arrives while the store holds `DEPTH` flits and no read happens in that cycle is discarded. `err_o` goes high in the next cycle.
- R4: `err_o` goes high in the cycle after all of these hold together: `rd_ready_i`=1, `retx_pending_i`=0, the store is empty, and at least one flit has been stored since reset. Before the first stored flit, or while `retx_pending_i`=1, an empty store raises no error.
- R5: A filler write (`wr_fill_i`=1) is discarded when the occupancy is at least `DROP_LEVEL` (default 2). Below that level it is stored and delivered with `rd_fill_o`=1.
- R6: While `retx_pending_i`=1, `rd_valid_o` is low and no flit is removed.
- R7: Suppose the stream runs at one flit per four cycles, each segment has at least ten filler flits, and at most one 40-cycle stall falls inside each segment's data portion. Then every data flit is delivered in order and `err_o` stays low.
- R8: Once set, `err_o` stays high until reset.
- R9: A flit written into an empty store is presented on the read port in the next cycle, with `rd_valid_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Tester flit present this cycle |
| wr_fill_i | input | 1 | Marker: 1 = filler flit, 0 = test data |
| wr_data_i | input | 32 | Tester flit payload |
| retx_pending_i | input | 1 | Fabric is retransmitting; read port stalled |
| rd_ready_i | input | 1 | Fabric accepts a flit this cycle |
| rd_valid_o | output | 1 | Head flit is offered |
| rd_fill_o | output | 1 | Marker of the offered flit |
| rd_data_o | output | 32 | Payload of the offered flit |
| err_o | output | 1 | Sticky overflow / underflow flag |

## Verification
The hardest case to reach from the ports is the recovery after a stall. The buffer must build a backlog of about ten flits and then lose it again by discarding filler, all without ever running dry while the fabric is still asking for data. The bench gets there with a paced writer and reader that both work on a four-cycle cadence. Each segment gets one 40-cycle retransmission window at a random point inside its data portion. The bench then checks three things: every data flit arrives in order, the flag stays low, and fewer filler flits arrive than a stall-free run delivers.

// File: rtl/jtb_pkg.sv
package jtb_pkg;
  // Flit payload width of the tester stream.
  parameter int JTB_FLIT_W = 32;

  // One stored entry: marker bit plus payload.
  typedef struct packed {
    logic                  fill;
    logic [JTB_FLIT_W-1:0] data;
  } jtb_flit_t;
endpackage

// File: rtl/jtb_store.sv
module jtb_store
  import jtb_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW  = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  jtb_flit_t     wdata,
  output jtb_flit_t     rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam bit POW2 = ((1 << AW) == DEPTH);

  jtb_flit_t     mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q, wptr_d, rptr_d, wptr_inc, rptr_inc;
  logic [CW-1:0] count_q, count_d;

  // Pointer wrap: free-running for a power-of-two depth, compare otherwise.
  generate
    if (POW2) begin : g_wrap_pow2
      assign wptr_inc = wptr_q + 1'b1;
      assign rptr_inc = rptr_q + 1'b1;
    end else begin : g_wrap_cmp
      assign wptr_inc = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      assign rptr_inc = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    end
  endgenerate

  always_comb begin
    wptr_d  = push ? wptr_inc : wptr_q;
    rptr_d  = pop  ? rptr_inc : rptr_q;
    count_d = count_q;
    if (push && !pop) count_d = count_q + 1'b1;
    else if (pop && !push) count_d = count_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      count_q <= count_d;
    end
  end

  // Storage array: write-enabled, no reset needed.
  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= wdata;
  end

  assign rdata = mem[rptr_q];
  assign count = count_q;
  assign full  = (count_q == CW'(DEPTH));
  assign empty = (count_q == '0);
endmodule

// File: rtl/jtb_admit.sv
module jtb_admit #(
  parameter int DEPTH      = 16,
  parameter int DROP_LEVEL = 2,
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic          wr_valid,
  input  logic          wr_fill,
  input  logic [CW-1:0] count,
  input  logic          full,
  input  logic          pop,
  output logic          push,
  output logic          drop,
  output logic          overflow
);
  logic keep;

  // Filler is shed only when a backlog exists; that is how the reserve refills.
  always_comb begin
    drop     = wr_valid && wr_fill && (count >= CW'(DROP_LEVEL));
    keep     = wr_valid && !drop;
    push     = keep && (!full || pop);
    overflow = keep && full && !pop;
  end
endmodule

// File: rtl/jtb_errmon.sv
module jtb_errmon (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic overflow,
  input  logic rd_ready,
  input  logic stalled,
  input  logic empty,
  output logic started,
  output logic err
);
  logic started_q, started_d, err_q, err_d, underflow;

  always_comb begin
    underflow = started_q && rd_ready && !stalled && empty;
    started_d = started_q || push;
    err_d     = err_q || overflow || underflow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      started_q <= started_d;
      err_q     <= err_d;
    end
  end

  assign started = started_q;
  assign err     = err_q;
endmodule

// File: rtl/jitter_buf.sv
module jitter_buf
  import jtb_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int DROP_LEVEL = 2,
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid_i,
  input  logic                  wr_fill_i,
  input  logic [JTB_FLIT_W-1:0] wr_data_i,
  input  logic                  retx_pending_i,
  input  logic                  rd_ready_i,
  output logic                  rd_valid_o,
  output logic                  rd_fill_o,
  output logic [JTB_FLIT_W-1:0] rd_data_o,
  output logic                  err_o
);
  jtb_flit_t     wflit, hflit;
  logic [CW-1:0] fill_count;
  logic          is_full, is_empty, push, pop, drop, overflow, stream_started;

  assign wflit      = '{fill: wr_fill_i, data: wr_data_i};
  assign rd_valid_o = !is_empty && !retx_pending_i;
  assign pop        = rd_valid_o && rd_ready_i;
  assign rd_fill_o  = hflit.fill;
  assign rd_data_o  = hflit.data;

  jtb_admit #(.DEPTH(DEPTH), .DROP_LEVEL(DROP_LEVEL)) u_admit (
    .wr_valid (wr_valid_i),
    .wr_fill  (wr_fill_i),
    .count    (fill_count),
    .full     (is_full),
    .pop      (pop),
    .push     (push),
    .drop     (drop),
    .overflow (overflow)
  );

  jtb_store #(.DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .wdata (wflit),
    .rdata (hflit),
    .count (fill_count),
    .full  (is_full),
    .empty (is_empty)
  );

  jtb_errmon u_err (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .overflow (overflow),
    .rd_ready (rd_ready_i),
    .stalled  (retx_pending_i),
    .empty    (is_empty),
    .started  (stream_started),
    .err      (err_o)
  );
endmodule

// File: rtl/jitter_buf_chk.sv
module jitter_buf_chk #(
  parameter int DEPTH      = 16,
  parameter int DROP_LEVEL = 2,
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid_i,
  input logic          wr_fill_i,
  input logic          retx_pending_i,
  input logic          rd_ready_i,
  input logic          rd_valid_o,
  input logic [31:0]   rd_data_o,
  input logic          err_o,
  input logic [CW-1:0] count,
  input logic          started
);
  logic taken;
  assign taken = rd_valid_o && rd_ready_i;

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!err_o && !rd_valid_o));

  assert_head_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |=> $stable(rd_data_o));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && !(wr_fill_i && count >= CW'(DROP_LEVEL)) && count == CW'(DEPTH) && !taken)
      |=> err_o);

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_underflow_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (started && rd_ready_i && !retx_pending_i && count == '0) |=> err_o);

  assert_filler_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && wr_fill_i && count >= CW'(DROP_LEVEL) && !taken) |=> (count == $past(count)));

  assert_stall_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    retx_pending_i |-> !rd_valid_o);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  assert_offer_when_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0 && !retx_pending_i) |-> rd_valid_o);
endmodule

bind jitter_buf jitter_buf_chk #(.DEPTH(DEPTH), .DROP_LEVEL(DROP_LEVEL)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wr_valid_i     (wr_valid_i),
  .wr_fill_i      (wr_fill_i),
  .retx_pending_i (retx_pending_i),
  .rd_ready_i     (rd_ready_i),
  .rd_valid_o     (rd_valid_o),
  .rd_data_o      (rd_data_o),
  .err_o          (err_o),
  .count          (fill_count),
  .started        (stream_started)
);

// File: tb/jitter_buf_bench.sv
module jitter_buf_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int PER        = 4;
  localparam int SEG        = 30;
  localparam int GAP        = 12;
  localparam int STALL      = 40;
  localparam int NSEG       = 4;
  localparam int PERC       = (SEG + GAP) * PER;
  localparam int LIMIT      = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid_i = 1'b0, wr_fill_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        retx_pending_i = 1'b0, rd_ready_i = 1'b0;
  logic        rd_valid_o, rd_fill_o, err_o;
  logic [31:0] rd_data_o;

  int vectors = 0, fails = 0, cyc = 0, base = 0;
  int st [NSEG];
  logic [31:0] exp_q [$];

  jitter_buf #(.DEPTH(DEPTH), .DROP_LEVEL(2)) u_jitter_buf (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (cyc > LIMIT) begin
      fails++;
      $display("FAIL watchdog: run hung act=%0d exp<=%0d", cyc, LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_valid_i = 0; wr_fill_i = 0; retx_pending_i = 0; rd_ready_i = 0;
    exp_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Driver: one-cycle write; data flits go to the scoreboard.
  task automatic put(input logic fill, input logic [31:0] d);
    wr_valid_i = 1'b1; wr_fill_i = fill; wr_data_i = d;
    if (!fill) exp_q.push_back(d);
    @(negedge clk);
    wr_valid_i = 1'b0;
  endtask

  task automatic run_writer(input int nseg);
    for (int s = 0; s < nseg; s++) begin
      for (int i = 0; i < SEG + GAP; i++) begin
        if (!(s == 0 && i == 0)) do @(negedge clk); while (cyc % PER != 0);
        wr_valid_i = 1'b1;
        wr_fill_i  = (i >= SEG);
        wr_data_i  = (i < SEG) ? 32'hD000_0000 + 32'(s * 256 + i) : 32'hF111_0000 + 32'(i);
        if (i < SEG) exp_q.push_back(wr_data_i);
        @(negedge clk);
        wr_valid_i = 1'b0;
      end
    end
  endtask

  // Monitor on the fabric side: paced reads, stall windows, scoreboard compare.
  task automatic run_reader(input int nseg, input bit stalls, input string req,
                            output int fills, output int viol);
    int got, rel, seg, off;
    logic [31:0] e;
    got = 0; fills = 0; viol = 0;
    while (got < nseg * SEG) begin
      @(negedge clk);
      rel = cyc - base; seg = rel / PERC; off = rel % PERC;
      retx_pending_i = stalls && (seg < nseg) && (off >= st[seg]) && (off < st[seg] + STALL);
      rd_ready_i     = (rel % PER == 2);
      #1;
      if (retx_pending_i && rd_valid_o) viol++;
      if (rd_ready_i && rd_valid_o) begin
        if (rd_fill_o) fills++;
        else begin
          got++;
          if (exp_q.size() == 0) check(1'b0, req, rd_data_o, 32'h0);
          else begin
            e = exp_q.pop_front();
            check(rd_data_o == e, req, rd_data_o, e);
          end
        end
      end
    end
    @(negedge clk);
    rd_ready_i = 1'b0; retx_pending_i = 1'b0;
  endtask

  task automatic run_stream(input bit stalls, input string req, output int fills, output int viol);
    do @(negedge clk); while (cyc % PER != 0);
    base = cyc;
    fork
      run_writer(NSEG);
      run_reader(NSEG, stalls, req, fills, viol);
    join
  endtask

  initial begin
    int fills, viol;
    for (int s = 0; s < NSEG; s++) st[s] = 8 + $urandom_range(0, SEG * PER - 60);

    // R1: quiet reset, even with the fabric asking (nothing stored yet, so no R4 error).
    rst_n = 1'b0; rd_ready_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(rd_valid_o == 1'b0, "R1 valid after reset", rd_valid_o, 0);
    check(err_o == 1'b0, "R1 R4 no error before first flit", err_o, 0);
    rd_ready_i = 1'b0;

    // R9 then R5: data visible next cycle; filler kept below level, dropped at level.
    put(1'b0, 32'hA5A5_0001);
    #1;
    check(rd_valid_o == 1'b1, "R9 valid next cycle", rd_valid_o, 1);
    check(rd_data_o == 32'hA5A5_0001, "R9 head data", rd_data_o, 32'hA5A5_0001);
    put(1'b1, 32'hF0F0_0001);   // occupancy 1 -> stored
    put(1'b1, 32'hF0F0_0002);   // occupancy 2 -> dropped
    rd_ready_i = 1'b1; #1;
    check(rd_data_o == 32'hA5A5_0001 && !rd_fill_o, "R2 first out", rd_data_o, 32'hA5A5_0001);
    void'(exp_q.pop_front());
    @(negedge clk); #1;
    check(rd_valid_o && rd_fill_o, "R5 kept filler marked", {rd_valid_o, rd_fill_o}, 2'b11);
    check(rd_data_o == 32'hF0F0_0001, "R5 kept filler data", rd_data_o, 32'hF0F0_0001);
    @(negedge clk);
    rd_ready_i = 1'b0; #1;
    check(rd_valid_o == 1'b0, "R5 second filler dropped", rd_valid_o, 0);
    check(err_o == 1'b0, "R4 no error without demand", err_o, 0);

    // R4 suppression by stall on an empty store, then R6 blocking, then underflow.
    retx_pending_i = 1'b1; rd_ready_i = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check(err_o == 1'b0, "R4 stalled empty is not underflow", err_o, 0);
    rd_ready_i = 1'b0;
    put(1'b0, 32'hB0B0_0002);
    rd_ready_i = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check(rd_valid_o == 1'b0, "R6 valid low during stall", rd_valid_o, 0);
    retx_pending_i = 1'b0; #1;
    check(rd_valid_o && rd_data_o == 32'hB0B0_0002, "R6 flit kept through stall", rd_data_o, 32'hB0B0_0002);
    void'(exp_q.pop_front());
    @(negedge clk); #1;
    check(err_o == 1'b0, "R4 not yet flagged", err_o, 0);
    @(negedge clk); #1;
    check(err_o == 1'b1, "R4 underflow flagged", err_o, 1);
    rd_ready_i = 1'b0;
    repeat (5) @(negedge clk);
    #1;
    check(err_o == 1'b1, "R8 flag sticky", err_o, 1);
    do_reset();
    #1;
    check(err_o == 1'b0, "R8 cleared by reset", err_o, 0);

    // R3: DEPTH+1 back-to-back data writes with no reads.
    for (int i = 0; i <= DEPTH; i++) begin
      if (i == DEPTH) begin
        #1;
        check(err_o == 1'b0, "R3 no flag while room", err_o, 0);
      end
      wr_valid_i = 1'b1; wr_fill_i = 1'b0; wr_data_i = 32'(i);
      @(negedge clk);
    end
    wr_valid_i = 1'b0; #1;
    check(err_o == 1'b1, "R3 overflow flagged", err_o, 1);
    rd_ready_i = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      #1;
      check(rd_valid_o && rd_data_o == 32'(k), "R3 R2 kept flits in order", rd_data_o, 32'(k));
      @(negedge clk);
    end
    rd_ready_i = 1'b0; #1;
    check(rd_valid_o == 1'b0, "R3 extra flit discarded", rd_valid_o, 0);
    do_reset();

    // R2 R5: clean stream, every filler passes through.
    run_stream(1'b0, "R2 clean stream order", fills, viol);
    check(fills == (NSEG - 1) * GAP, "R5 fillers pass when no backlog", 32'(fills), 32'((NSEG - 1) * GAP));
    check(err_o == 1'b0, "R2 clean stream no error", err_o, 0);
    do_reset();

    // R7: one 40-cycle retransmission per segment.
    run_stream(1'b1, "R7 stalled stream order", fills, viol);
    check(viol == 0, "R6 no offer during stall windows", 32'(viol), 0);
    check(fills < (NSEG - 1) * GAP, "R5 fillers shed after stall", 32'(fills), 32'((NSEG - 1) * GAP));
    check(exp_q.size() == 0, "R7 all data delivered", 32'(exp_q.size()), 0);
    check(err_o == 1'b0, "R7 no error with one stall per segment", err_o, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule